// File: doc/BRIEF.md
# Binary64 Round-to-Integral Unit

This block takes a binary64 floating-point operand and rounds it to an integral value. The result stays in floating-point encoding. Rounding follows a 3-bit mode input. One control bit decides whether the unit may report inexact. Results come out one clock after the operand, with a valid strobe, so the unit fits as one stage of a floating-point pipeline.

Zero and infinity pass through unchanged. Operands whose exponent already makes them integral also pass through unchanged. Any NaN is replaced by the canonical quiet NaN and raises invalid. Magnitudes below one collapse to a signed zero or to a signed one. A round-up that carries out of the significand moves into the exponent.

Top module: `round_integral_unit`

## Requirements
- R1: While reset is asserted, out_valid, result, flag_invalid and flag_inexact are all zero.
- R2: out_valid is high exactly one clock after a cycle with in_valid high and low after a cycle with in_valid low. result and the flags are registered in that same clock.
- R3: A zero or infinite operand of either sign is returned bit-for-bit, with both flags low.
- R4: Any NaN operand, quiet or signalling, of either sign, gives result 0x7FF8000000000000, flag_invalid high and flag_inexact low.
- R5: A finite operand with biased exponent of 1075 or more is already integral. It is returned bit-for-bit, with both flags low.
- R6: The rmode codes are 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity and 4 nearest with ties away from zero. Codes 5 to 7 act as code 0. The result is the integral value that the selected direction picks.
- R7: In nearest-even mode, an operand exactly halfway between two integers rounds to the one whose value is even.
- R8: A nonzero operand with magnitude below 1.0 yields ±0.0 or ±1.0, depending on the mode. The operand's sign is always kept.
- R9: When rounding up reaches the next power of two, the exponent field is incremented and the mantissa field becomes zero.
- R10: With signal_inexact high, flag_inexact is high exactly when the result differs from a non-NaN operand.
- R11: With signal_inexact low, flag_inexact is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 64 | binary64 value to round |
| rmode | input | 3 | Rounding direction code |
| signal_inexact | input | 1 | Allows flag_inexact to be raised |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Rounded value, binary64 encoding |
| flag_invalid | output | 1 | Operand was a NaN |
| flag_inexact | output | 1 | Rounding changed the value (when allowed) |

## Verification
The internal state that can go wrong is the round-up decision: the guard and sticky bits or the mode decode. An error there appears one clock later as a result one unit off in the last integral place, with the inexact flag possibly disagreeing with it. A wrong operand class shows up on the next out_valid in one of three ways: a special value modified instead of passed through, a NaN that is not canonical, or a misplaced sign on a tiny operand. A lost carry appears in that same cycle as a mantissa wrapping to zero while the exponent stays put. The bench compares every output against a real-arithmetic model on every clock, so each such fault is visible on the first affected output cycle.

// File: rtl/fri_pkg.sv
package fri_pkg;

  localparam int RM_W = 3;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_TO_ZERO   = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_MAX  = 3'd4
  } rmode_e;

  // One-hot operand class; exactly one bit set per operand.
  typedef struct packed {
    logic nan;
    logic inf;
    logic zero;
    logic integral;
    logic tiny;
    logic normal;
  } fclass_t;

  // Increment decision from the kept LSB, the first discarded bit and the OR of the rest.
  function automatic logic decide_up(input logic [RM_W-1:0] mode, input logic sign,
                                     input logic lsb, input logic half, input logic sticky);
    logic any;
    any = half | sticky;
    case (mode)
      RM_TO_ZERO:  decide_up = 1'b0;
      RM_DOWN:     decide_up = sign & any;
      RM_UP:       decide_up = ~sign & any;
      RM_NEAR_MAX: decide_up = half;
      default:     decide_up = half & (sticky | lsb);
    endcase
  endfunction

endpackage

// File: rtl/fri_classify.sv
module fri_classify
  import fri_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] operand,
  output fclass_t              cls
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_INT = EXP_W'(BIAS + MAN_W);
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic             ex_max, mn_zero;

  assign ex      = operand[EXP_W+MAN_W-1:MAN_W];
  assign mn      = operand[MAN_W-1:0];
  assign ex_max  = &ex;
  assign mn_zero = ~|mn;

  always_comb begin
    cls          = '0;
    cls.nan      = ex_max & ~mn_zero;
    cls.inf      = ex_max & mn_zero;
    cls.zero     = (ex == '0) & mn_zero;
    cls.integral = ~ex_max & (ex >= EXP_INT);
    cls.tiny     = (ex < EXP_ONE) & ~cls.zero;
    cls.normal   = (ex >= EXP_ONE) & (ex < EXP_INT);
  end

endmodule

// File: rtl/fri_round_core.sv
module fri_round_core
  import fri_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] operand,
  input  logic [RM_W-1:0]      rmode,
  input  fclass_t              cls,
  output logic [EXP_W+MAN_W:0] rounded,
  output logic                 lost,
  output logic                 carry
);
  localparam int FW   = 1 + EXP_W + MAN_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int XW   = MAN_W + 2;
  localparam logic [FW-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [XW-1:0] ONE   = XW'(1);

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  assign sgn = operand[FW-1];
  assign ex  = operand[FW-2:MAN_W];
  assign mn  = operand[MAN_W-1:0];

  // Normal path: drop fsh fraction bits from the 53-bit significand.
  logic [EXP_W:0] fsh;
  logic [XW-1:0]  sig, lsb_pos, half_pos, mask, trunc, sum, shifted;
  logic           n_half, n_sticky, n_lsb, n_up;

  assign fsh      = (EXP_W+1)'(BIAS + MAN_W) - {1'b0, ex};
  assign sig      = {2'b01, mn};
  assign lsb_pos  = ONE << fsh;
  assign half_pos = lsb_pos >> 1;
  assign mask     = lsb_pos - ONE;
  assign shifted  = sig >> fsh;
  assign n_lsb    = shifted[0];
  assign n_half   = |(sig & half_pos);
  assign n_sticky = |(sig & (half_pos - ONE));
  assign n_up     = decide_up(rmode, sgn, n_lsb, n_half, n_sticky);
  assign trunc    = sig & ~mask;
  assign sum      = trunc + (n_up ? lsb_pos : '0);

  // Tiny path: the integer part is zero, so the kept LSB is zero.
  logic t_half, t_sticky, t_up;
  assign t_half   = (ex == EXP_W'(BIAS - 1));
  assign t_sticky = t_half ? |mn : 1'b1;
  assign t_up     = decide_up(rmode, sgn, 1'b0, t_half, t_sticky);

  always_comb begin
    rounded = operand;
    lost    = 1'b0;
    carry   = 1'b0;
    if (cls.nan) begin
      rounded = CANON;
    end else if (cls.tiny) begin
      lost    = 1'b1;
      rounded = t_up ? {sgn, EXP_W'(BIAS), MAN_W'(0)} : {sgn, {(FW-1){1'b0}}};
    end else if (cls.normal) begin
      lost    = n_half | n_sticky;
      carry   = sum[XW-1];
      rounded = {sgn, ex + EXP_W'(carry), sum[MAN_W-1:0]};
    end
  end

endmodule

// File: rtl/round_integral_unit.sv
module round_integral_unit
  import fri_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] operand,
  input  logic [2:0]           rmode,
  input  logic                 signal_inexact,
  output logic                 out_valid,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 flag_invalid,
  output logic                 flag_inexact
);
  localparam int FW   = 1 + EXP_W + MAN_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [FW-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  fclass_t       op_cls;
  logic [FW-1:0] rnd_value;
  logic          rnd_lost, rnd_carry;

  fri_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
    .operand (operand),
    .cls     (op_cls)
  );

  fri_round_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_core (
    .operand (operand),
    .rmode   (rmode),
    .cls     (op_cls),
    .rounded (rnd_value),
    .lost    (rnd_lost),
    .carry   (rnd_carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= rnd_value;
        flag_invalid <= op_cls.nan;
        flag_inexact <= signal_inexact & rnd_lost;
      end
    end
  end

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_cls)); // R3
  AST_SPECIAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op_cls.zero || op_cls.inf) |=> result == $past(operand) && !flag_invalid && !flag_inexact); // R3
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_cls.nan |=> result == CANON && flag_invalid && !flag_inexact); // R4
  AST_BIG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_cls.integral |=> result == $past(operand) && !flag_inexact); // R5
  AST_TINY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_cls.tiny |=> result[FW-1] == $past(operand[FW-1]) &&
      (result[FW-2:0] == '0 || result[FW-2:0] == {EXP_W'(BIAS), MAN_W'(0)})); // R8
  AST_CARRY_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rnd_carry |=> result[FW-2:MAN_W] == $past(operand[FW-2:MAN_W]) + 1'b1 &&
      result[MAN_W-1:0] == '0); // R9
  AST_EXACT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op_cls.nan && !rnd_lost |=> result == $past(operand) && !flag_inexact); // R10
  AST_QUIET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !signal_inexact |=> !flag_inexact); // R11

endmodule

// File: tb/test_round_integral_unit.sv
`timescale 1ns/1ps
module test_round_integral_unit;
  logic        clk = 1'b0;
  logic        rst_n, in_valid, signal_inexact;
  logic [63:0] operand;
  logic [2:0]  rmode;
  logic        out_valid, flag_invalid, flag_inexact;
  logic [63:0] result;

  always #4 clk = ~clk;

  round_integral_unit i_round_integral_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand), .rmode(rmode),
    .signal_inexact(signal_inexact), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
  );

  int n_tests = 0, n_fail = 0;
  logic        e_valid = 1'b0;
  logic [63:0] e_res = '0;
  logic        e_inv = 1'b0, e_inx = 1'b0;
  string       e_tag = "R2";

  function automatic logic [63:0] fb(input real x);
    return $realtobits(x);
  endfunction

  // Behavioural model on real arithmetic, magnitude first, sign restored after.
  function automatic void model(input logic [63:0] b, input logic [2:0] m, input logic sx,
                                output logic [63:0] r, output logic inv, output logic inx);
    real a, fa, da, ra;
    logic up;
    inv = 1'b0; inx = 1'b0; r = b;
    if (b[62:52] == 11'h7FF) begin
      if (b[51:0] != 0) begin r = 64'h7FF8000000000000; inv = 1'b1; end
      return;
    end
    if (b[62:0] == 0) return;
    a  = $bitstoreal({1'b0, b[62:0]});
    fa = $floor(a);
    da = a - fa;
    case (m)
      3'd1: up = 1'b0;
      3'd2: up = b[63] && da > 0.0;
      3'd3: up = !b[63] && da > 0.0;
      3'd4: up = da >= 0.5;
      default: up = (da > 0.5) || (da == 0.5 && (fa / 2.0) != $floor(fa / 2.0));
    endcase
    ra = up ? fa + 1.0 : fa;
    r = $realtobits(ra);
    r[63] = b[63];
    inx = sx && (da != 0.0);
  endfunction

  task automatic note(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [63:0] b, input logic [2:0] m,
                      input logic sx, input string tag);
    @(negedge clk);
    note(out_valid == e_valid, e_tag, "out_valid", 64'(out_valid), 64'(e_valid));
    if (e_valid) begin
      note(result == e_res, e_tag, "result", result, e_res);
      note(flag_invalid == e_inv, e_tag, "invalid", 64'(flag_invalid), 64'(e_inv));
      note(flag_inexact == e_inx, e_tag, "inexact", 64'(flag_inexact), 64'(e_inx));
    end
    in_valid = v; operand = b; rmode = m; signal_inexact = sx;
    e_valid = v;
    e_tag = v ? tag : "R2";
    if (v) model(b, m, sx, e_res, e_inv, e_inx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; operand = '0; rmode = '0; signal_inexact = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    note(out_valid == 1'b0, "R1", "reset valid", 64'(out_valid), 64'd0);
    note(result == 64'd0, "R1", "reset result", result, 64'd0);
    note(flag_invalid == 1'b0 && flag_inexact == 1'b0, "R1", "reset flags",
         {62'd0, flag_invalid, flag_inexact}, 64'd0);
    rst_n = 1'b1;

    // R7 ties to even
    step(1, fb(2.5), 0, 1, "R7");
    step(1, fb(3.5), 0, 1, "R7");
    step(1, fb(-2.5), 0, 1, "R7");
    step(1, fb(-5.5), 0, 1, "R7");
    // R6 every mode, both signs, reserved codes
    for (int m = 0; m < 8; m++) begin
      step(1, fb(2.3), 3'(m), 1, "R6");
      step(1, fb(-2.7), 3'(m), 1, "R6");
      step(1, fb(6.5), 3'(m), 1, "R6");
      step(1, fb(-6.5), 3'(m), 1, "R6");
    end
    step(1, fb(123456.75), 4, 1, "R6");
    // R2 idle gaps
    step(0, fb(9.9), 0, 1, "R2");
    step(0, 64'h0, 0, 1, "R2");
    // R8 tiny magnitudes
    for (int m = 0; m < 5; m++) begin
      step(1, fb(0.3), 3'(m), 1, "R8");
      step(1, fb(-0.3), 3'(m), 1, "R8");
      step(1, fb(0.5), 3'(m), 1, "R8");
      step(1, fb(-0.5), 3'(m), 1, "R8");
      step(1, fb(0.7), 3'(m), 1, "R8");
      step(1, 64'h0000000000000001, 3'(m), 1, "R8");
      step(1, 64'h8000000000000001, 3'(m), 1, "R8");
    end
    // R9 carry into exponent
    step(1, fb(1.75), 3, 1, "R9");
    step(1, fb(-1.75), 2, 1, "R9");
    step(1, fb(4503599627370495.5), 0, 1, "R9");
    step(1, fb(0.999), 4, 1, "R9");
    // R3 zero and infinity
    step(1, 64'h0000000000000000, 3, 1, "R3");
    step(1, 64'h8000000000000000, 2, 1, "R3");
    step(1, 64'h7FF0000000000000, 0, 1, "R3");
    step(1, 64'hFFF0000000000000, 4, 1, "R3");
    // R5 already integral
    step(1, fb(4503599627370497.0), 3, 1, "R5");
    step(1, 64'h43B0000000000001, 2, 1, "R5");
    step(1, 64'hC7E0000000000123, 3, 1, "R5");
    // R4 NaNs
    step(1, 64'h7FF8000000000001, 0, 1, "R4");
    step(1, 64'h7FF0000000000001, 3, 1, "R4");
    step(1, 64'hFFFC000000000000, 1, 0, "R4");
    // R10 exact and inexact with signalling on
    step(1, fb(3.0), 0, 1, "R10");
    step(1, fb(-1024.0), 3, 1, "R10");
    step(1, fb(7.25), 1, 1, "R10");
    // R11 signalling off
    step(1, fb(2.3), 0, 0, "R11");
    step(1, fb(-0.3), 2, 0, "R11");
    step(1, fb(1.75), 3, 0, "R11");
    step(0, 64'h0, 0, 0, "R2");
    step(0, 64'h0, 0, 0, "R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule